// File: doc/BRIEF.md
# Ethernet Destination Address Filter

The block decides, for each received frame, whether its 48-bit destination address earns the frame a trip to the CPU. A parser upstream presents the address with a one-cycle strobe. Exactly one cycle later the block returns an accept or drop verdict. With that verdict it reports whether a table entry matched and, if so, which one. A register write port programs eight address entries, the class policy bits and a promiscuous override.

The table is split into two fixed regions. Entries 0 and 1 serve unicast destinations, and entries 2 to 7 serve multicast destinations. Each entry carries its own enable flag and its own forward flag. Per-class pass-all bits let software fall back to coarse acceptance when it has more addresses than the table holds. The promiscuous bit accepts every frame.

Addresses are in transmission order. Byte 0 is the first byte on the wire and sits in `da_addr_i[47:40]`. Byte 5 sits in `da_addr_i[7:0]`.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset all entries are disabled and all policy and promiscuous bits are 0, so every lookup is dropped with no hit, and `dec_valid_o`, `accept_o` and `hit_o` are 0 until a lookup is made.
- R2: `dec_valid_o` is 1 in exactly the cycle after a cycle with `da_valid_i` = 1. In any other cycle `dec_valid_o`, `accept_o` and `hit_o` are 0.
- R3: Write index 2k sets address bytes 2..5 of entry k, with byte 2 in bits 31:24. Write index 2k+1 sets bytes 0..1 in bits 15:0 (byte 0 in bits 15:8), the enable flag from bit 17 and the forward flag from bit 21. Index 16 is the policy word and index 17 bit 0 is the promiscuous bit.
- R4: An address is multicast when bit 0 of byte 0 (`da_addr_i[40]`) is 1. It is broadcast when all 48 bits are 1.
- R5: A unicast address is compared only with entries 0..1, and a non-broadcast multicast address only with entries 2..7. A broadcast address never hits. `hit_o` / `hit_idx_o` give the lowest-index enabled entry in the region whose address equals the destination.
- R6: A table hit accepts the frame only when the forward flag of the reported entry is 1.
- R7: Policy bit 1 (unicast pass-all) accepts every unicast address.
- R8: Policy bit 3 (multicast pass-all) accepts every non-broadcast multicast address.
- R9: Policy bit 5 accepts broadcast addresses. Without it a broadcast address is dropped unless the promiscuous bit is set.
- R10: Policy bit 7 enables the table. When it is 0, `hit_o` stays 0 and only the pass-all bits and the promiscuous bit can accept.
- R11: With the promiscuous bit set, every lookup is accepted regardless of table and policy bits.
- R12: A lookup in the same cycle as a register write uses the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| da_valid_i | input | 1 | Destination address strobe |
| da_addr_i | input | 48 | Destination address, byte 0 in bits 47:40 |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 5 | Register index |
| wr_data_i | input | 32 | Register write data |
| dec_valid_o | output | 1 | Verdict valid |
| accept_o | output | 1 | Frame forwarded to CPU |
| hit_o | output | 1 | A table entry matched |
| hit_idx_o | output | 3 | Index of the matching entry |

## Verification
A corrupt entry register, a swapped byte lane or a wrong region mask shows on the first lookup of the affected address. The symptom is a missing or extra `hit_o`, or a wrong `hit_idx_o`, in the cycle after the strobe. A broken priority encoder shows only where two entries hold the same address with different forward flags, so the table carries such duplicates in both directions. A policy bit stuck or wired to the wrong class shows as a wrong `accept_o` for that class alone. The sweep covers every combination of policy and promiscuous bits against every address class.

// File: rtl/dst_filt_pkg.sv
package dst_filt_pkg;
  localparam int DA_W      = 48;
  localparam int DATA_W    = 32;
  localparam int HI_W      = DA_W - DATA_W;
  localparam int EN_BIT    = 17;
  localparam int FWD_BIT   = 21;
  localparam int UC_ALL_BIT = 1;
  localparam int MC_ALL_BIT = 3;
  localparam int BC_BIT     = 5;
  localparam int TBL_EN_BIT = 7;
  localparam int PROM_BIT   = 0;
  localparam int MC_FLAG_BIT = DA_W - 8;

  typedef struct packed {
    logic promisc;
    logic tbl_en;
    logic bc_all;
    logic mc_all;
    logic uc_all;
  } flt_ctrl_t;
endpackage

// File: rtl/flt_entry.sv
module flt_entry
  import dst_filt_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int ENTRY_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DA_W-1:0]   addr_i,
  output logic              match_o,
  output logic              fwd_o
);
  localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(2 * ENTRY_ID);
  localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(2 * ENTRY_ID + 1);

  logic [DA_W-1:0] addr_q;
  logic            en_q, fwd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      en_q   <= 1'b0;
      fwd_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_idx_i == LO_IDX) addr_q[DATA_W-1:0] <= wr_data_i;
      if (wr_idx_i == HI_IDX) begin
        addr_q[DA_W-1:DATA_W] <= wr_data_i[HI_W-1:0];
        en_q  <= wr_data_i[EN_BIT];
        fwd_q <= wr_data_i[FWD_BIT];
      end
    end
  end

  assign match_o = en_q && (addr_q == addr_i);
  assign fwd_o   = fwd_q;
endmodule

// File: rtl/flt_hit_pick.sv
module flt_hit_pick #(
  parameter int N   = 8,
  parameter int IW  = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/flt_policy.sv
module flt_policy
  import dst_filt_pkg::*;
(
  input  flt_ctrl_t ctrl_i,
  input  logic      is_bcast_i,
  input  logic      is_mc_i,
  input  logic      hit_i,
  input  logic      hit_fwd_i,
  output logic      accept_o
);
  logic tbl_pass;
  assign tbl_pass = hit_i && hit_fwd_i;

  always_comb begin
    if (ctrl_i.promisc)  accept_o = 1'b1;
    else if (is_bcast_i) accept_o = ctrl_i.bc_all;
    else if (is_mc_i)    accept_o = ctrl_i.mc_all || tbl_pass;
    else                 accept_o = ctrl_i.uc_all || tbl_pass;
  end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import dst_filt_pkg::*;
#(
  parameter int N_ENTRY = 8,
  parameter int N_UC    = 2,
  parameter int IDX_W   = $clog2(2 * N_ENTRY + 2),
  parameter int HIT_W   = $clog2(N_ENTRY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              da_valid_i,
  input  logic [DA_W-1:0]   da_addr_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              dec_valid_o,
  output logic              accept_o,
  output logic              hit_o,
  output logic [HIT_W-1:0]  hit_idx_o
);
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(2 * N_ENTRY);
  localparam logic [IDX_W-1:0] PROM_IDX = IDX_W'(2 * N_ENTRY + 1);

  flt_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      if (wr_idx_i == CTRL_IDX) begin
        ctrl_q.uc_all <= wr_data_i[UC_ALL_BIT];
        ctrl_q.mc_all <= wr_data_i[MC_ALL_BIT];
        ctrl_q.bc_all <= wr_data_i[BC_BIT];
        ctrl_q.tbl_en <= wr_data_i[TBL_EN_BIT];
      end
      if (wr_idx_i == PROM_IDX) ctrl_q.promisc <= wr_data_i[PROM_BIT];
    end
  end

  logic is_bcast, is_mc;
  assign is_bcast = &da_addr_i;
  assign is_mc    = da_addr_i[MC_FLAG_BIT];

  logic [N_ENTRY-1:0] match_vec, fwd_vec, cand_vec;

  for (genvar k = 0; k < N_ENTRY; k++) begin : g_entry
    flt_entry #(.IDX_W(IDX_W), .ENTRY_ID(k)) u_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_idx_i  (wr_idx_i),
      .wr_data_i (wr_data_i),
      .addr_i    (da_addr_i),
      .match_o   (match_vec[k]),
      .fwd_o     (fwd_vec[k])
    );
    if (k < N_UC) begin : g_uc
      assign cand_vec[k] = match_vec[k] && ctrl_q.tbl_en && !is_mc;
    end else begin : g_mc
      assign cand_vec[k] = match_vec[k] && ctrl_q.tbl_en && is_mc && !is_bcast;
    end
  end

  logic             hit_d;
  logic [HIT_W-1:0] hit_idx_d;
  logic             accept_d;

  flt_hit_pick #(.N(N_ENTRY), .IW(HIT_W)) u_pick (
    .req_i   (cand_vec),
    .found_o (hit_d),
    .idx_o   (hit_idx_d)
  );

  flt_policy u_policy (
    .ctrl_i     (ctrl_q),
    .is_bcast_i (is_bcast),
    .is_mc_i    (is_mc),
    .hit_i      (hit_d),
    .hit_fwd_i  (fwd_vec[hit_idx_d]),
    .accept_o   (accept_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      hit_o       <= 1'b0;
      hit_idx_o   <= '0;
    end else begin
      dec_valid_o <= da_valid_i;
      accept_o    <= da_valid_i && accept_d;
      hit_o       <= da_valid_i && hit_d;
      hit_idx_o   <= da_valid_i ? hit_idx_d : '0;
    end
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data_i;

  assert_verdict_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o == $past(da_valid_i));
  assert_quiet_outputs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> (!accept_o && !hit_o));
  assert_promisc_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && $past(ctrl_q.promisc)) |-> accept_o);
  assert_table_off_no_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !$past(ctrl_q.tbl_en)) |-> !hit_o);
  assert_hit_region_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((int'(hit_idx_o) >= N_UC) == $past(da_addr_i[MC_FLAG_BIT])));
  assert_bcast_no_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !$past(&da_addr_i));
  assert_bcast_policy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && $past(&da_addr_i) && !$past(ctrl_q.promisc)) |-> (accept_o == $past(ctrl_q.bc_all)));
endmodule

// File: tb/dst_addr_filter_bench.sv
module dst_addr_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int NQ = 10;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        dec_valid, accept, hit;
  logic [2:0]  hit_idx;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dst_addr_filter u_dst_addr_filter (
    .clk_i(clk), .rst_ni(rst_ni), .da_valid_i(da_valid), .da_addr_i(da_addr),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .dec_valid_o(dec_valid), .accept_o(accept), .hit_o(hit), .hit_idx_o(hit_idx)
  );

  logic [47:0] ent_addr [NE];
  bit          ent_en   [NE];
  bit          ent_fwd  [NE];
  logic [47:0] qry      [NQ];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] hi_word(input logic [47:0] a, input bit en, input bit fwd);
    return (32'(fwd) << 21) | (32'(en) << 17) | 32'(a[47:32]);
  endfunction

  task automatic prog_entry(input int k);
    wr(2 * k, ent_addr[k][31:0]);
    wr(2 * k + 1, hi_word(ent_addr[k], ent_en[k], ent_fwd[k]));
  endtask

  task automatic set_policy(input bit uc, input bit mc, input bit bc, input bit tbl, input bit pr);
    wr(16, (32'(tbl) << 7) | (32'(bc) << 5) | (32'(mc) << 3) | (32'(uc) << 1));
    wr(17, 32'(pr));
  endtask

  // reference decision from the requirements
  task automatic model(input logic [47:0] q, input bit uc, input bit mc, input bit bc,
                       input bit tbl, input bit pr,
                       output bit e_hit, output int e_idx, output bit e_acc);
    bit is_b, is_m;
    is_b = (q == '1);
    is_m = q[40];
    e_hit = 1'b0; e_idx = 0;
    if (tbl && !is_b) begin
      for (int k = 0; k < NE; k++) begin
        if (!e_hit && ent_en[k] && ent_addr[k] == q && ((k >= 2) == is_m)) begin
          e_hit = 1'b1; e_idx = k;
        end
      end
    end
    if (pr) e_acc = 1'b1;
    else if (is_b) e_acc = bc;
    else if (is_m) e_acc = mc || (e_hit && ent_fwd[e_idx]);
    else e_acc = uc || (e_hit && ent_fwd[e_idx]);
  endtask

  task automatic lookup(input logic [47:0] q, input bit e_hit, input int e_idx,
                        input bit e_acc, input string req);
    @(negedge clk);
    da_valid = 1'b1; da_addr = q;
    @(negedge clk);
    da_valid = 1'b0;
    chk({req, " R2 valid"}, 32'(dec_valid), 32'd1);
    chk({req, " accept"}, 32'(accept), 32'(e_acc));
    chk({req, " hit"}, 32'(hit), 32'(e_hit));
    if (e_hit) chk({req, " hit_idx"}, 32'(hit_idx), 32'(e_idx));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit e_hit, e_acc;
    int e_idx;
    ent_addr[0] = 48'h01005E000010; ent_en[0] = 1; ent_fwd[0] = 1; // mc address in uc region
    ent_addr[1] = 48'h021122334455; ent_en[1] = 1; ent_fwd[1] = 1;
    ent_addr[2] = 48'h04AABBCCDDEE; ent_en[2] = 1; ent_fwd[2] = 1; // uc address in mc region
    ent_addr[3] = 48'h01005E000003; ent_en[3] = 0; ent_fwd[3] = 1;
    ent_addr[4] = 48'h01005E000004; ent_en[4] = 1; ent_fwd[4] = 1;
    ent_addr[5] = 48'h333300000005; ent_en[5] = 1; ent_fwd[5] = 0;
    ent_addr[6] = 48'h333300000005; ent_en[6] = 1; ent_fwd[6] = 1;
    ent_addr[7] = 48'h01005E000004; ent_en[7] = 1; ent_fwd[7] = 0;
    for (int k = 0; k < 6; k++) qry[k] = ent_addr[k];
    qry[6] = 48'h000C29000001;
    qry[7] = 48'h0180C200000E;
    qry[8] = 48'hFFFFFFFFFFFF;
    qry[9] = 48'hFFFFFFFFFFFE;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 dec_valid", 32'(dec_valid), 0);
    chk("R1 accept", 32'(accept), 0);
    chk("R1 hit", 32'(hit), 0);
    lookup(qry[1], 0, 0, 0, "R1 empty table");
    lookup(qry[8], 0, 0, 0, "R1 bcast dropped");

    for (int k = 0; k < NE; k++) prog_entry(k);

    // R2: verdict lasts one cycle
    set_policy(1, 1, 1, 1, 0);
    lookup(qry[1], 1, 1, 1, "R2 pulse");
    @(negedge clk);
    chk("R2 valid drops", 32'(dec_valid), 0);
    chk("R2 accept drops", 32'(accept), 0);
    chk("R2 hit drops", 32'(hit), 0);

    // R3-R11: sweep of all policy combinations against all address classes
    for (int c = 0; c < 32; c++) begin
      set_policy(c[0], c[1], c[2], c[3], c[4]);
      for (int q = 0; q < NQ; q++) begin
        model(qry[q], c[0], c[1], c[2], c[3], c[4], e_hit, e_idx, e_acc);
        lookup(qry[q], e_hit, e_idx, e_acc, "R3 R4 R5 R6 R7 R8 R9 R10 R11 sweep");
      end
    end

    // R12: simultaneous write and lookup sees old table
    set_policy(0, 0, 0, 1, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd3; wr_data = hi_word(ent_addr[1], 0, 1);
    da_valid = 1'b1; da_addr = ent_addr[1];
    @(negedge clk);
    wr_en = 1'b0; da_valid = 1'b0;
    chk("R12 old entry hit", 32'(hit), 1);
    chk("R12 old entry accept", 32'(accept), 1);
    ent_en[1] = 0;
    lookup(ent_addr[1], 0, 0, 0, "R12 R3 entry disabled");

    // R3: byte lanes of a rewritten entry
    ent_addr[1] = 48'h0A0B0C0D0E0F; ent_en[1] = 1; ent_fwd[1] = 1;
    prog_entry(1);
    lookup(48'h0A0B0C0D0E0F, 1, 1, 1, "R3 new address");
    lookup(48'h0B0A0C0D0E0F, 0, 0, 0, "R3 bytes 0-1 swapped");
    lookup(48'h0A0B0F0E0D0C, 0, 0, 0, "R3 bytes 2-5 reversed");
    // R6: forward flag clear blocks acceptance
    wr(3, hi_word(ent_addr[1], 1, 0));
    lookup(48'h0A0B0C0D0E0F, 1, 1, 0, "R6 no forward");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule